// File: doc/BRIEF.md
# Three-Phase Stepped 16-bit Processor Core

This block is a small multicycle processor. Every instruction passes through three phases in a fixed order. In the fetch phase it reads an instruction word and moves the program counter on. In the decode phase it reads the two source registers named in the word. In the execute phase it runs the ALU and writes the result back, loads a constant, or issues a data store. The sequencer moves forward by one phase only on a clock edge where the step input is high. This lets a surrounding debug or demonstration harness walk through a program one phase at a time and watch the program counter, the instruction register, the current phase and the status flags.

The core has a word-addressed instruction memory inside it. The host fills this memory through a write port before it releases the core. Stores do not go to an internal memory: they leave the core as a one-cycle write strobe with an address and a data word, and an external data memory takes them. The core also holds sixteen general 16-bit registers.

Top module: `tcpu_core`

## Requirements
- R1: A synchronous reset sets pc, ir, flags and all sixteen registers to zero and puts the sequencer in fetch. The phase encoding is 0 fetch, 1 decode, 2 execute and 3 halted.
- R2: On each edge with step high the phase moves fetch→decode→execute→fetch. After a halt instruction, execute moves to halted instead.
- R3: On an edge with step low, pc, ir, phase and flags keep their values.
- R4: A step in fetch loads ir with the instruction memory word at pc and sets pc to pc+1. ir changes in no other phase.
- R5: The instruction fields are: opcode in bits [15:12], source A in [11:8], source B in [7:4] and destination in [3:0]. Opcode 0010 (ADD) writes A+B to the destination. Its carry is the carry out of bit 15.
- R6: Opcode 0011 (SUB) writes A−B to the destination. Carry is set when there is no borrow, that is when A ≥ B unsigned.
- R7: Opcode 0100 (AND) writes A&B to the destination and clears carry.
- R8: The flags output is {N,Z,C} in bits 2, 1 and 0. ADD, SUB and AND set N to bit 15 of the result and set Z when the result is zero. Flags change only in the execute phase, and load-constant and store leave them unchanged.
- R9: Opcode 0001 (load constant) writes the 8-bit value in bits [11:4], zero-extended, to the register in bits [3:0].
- R10: Opcode 0101 (store) raises dmemWe during its execute phase while step is high. dmemAddr is bits [7:0] and dmemData is the register named in bits [11:8]. dmemWe stays low at all other times.
- R11: Opcode 1111 (halt) puts the core in the halted phase. pc, registers and flags then stay frozen until reset.
- R12: Any other opcode passes through all three phases but writes no register, changes no flags and issues no store.
- R13: A write on the program port (progWe) stores progData at progAddr in the instruction memory. The next fetch from that address reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance one phase on this edge |
| progWe | input | 1 | Instruction memory write enable |
| progAddr | input | ADDR_W | Instruction memory write address |
| progData | input | 16 | Instruction word to write |
| pc | output | ADDR_W | Program counter |
| ir | output | 16 | Instruction register |
| phase | output | 2 | Current phase (0 fetch, 1 decode, 2 execute, 3 halted) |
| flags | output | 3 | {N,Z,C} status |
| dmemWe | output | 1 | Data store strobe |
| dmemAddr | output | 8 | Data store address |
| dmemData | output | 16 | Data store value |

## Verification
The bound checker watches the sequencing rules on every cycle:
- the phase order and the freeze while step is low;
- pc advancing only in fetch, and ir changing only in fetch;
- flags changing only in execute;
- the store strobe appearing only in an execute step;
- the halted state holding its pc.

The arithmetic can only be shown by the bench's programs, which run directed and random instruction streams against an expected-value model:
- sums, differences and the carry/borrow sense;
- AND results and the zero-extended constant;
- undefined opcodes changing nothing;
- registers still at zero after reset, which only shows when a later store reads them out.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  localparam int WORD_W = 16;
  localparam int REG_N  = 16;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2,
    PH_HALT   = 2'd3
  } phase_t;

  typedef enum logic [3:0] {
    OP_LDI   = 4'b0001,
    OP_ADD   = 4'b0010,
    OP_SUB   = 4'b0011,
    OP_AND   = 4'b0100,
    OP_STORE = 4'b0101,
    OP_HALT  = 4'b1111
  } opcode_t;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2
  } alu_op_t;

  typedef struct packed {
    logic    irLoad;
    logic    opLoad;
    logic    rfWrite;
    logic    immSel;
    logic    flagWrite;
    logic    storeEn;
    alu_op_t aluOp;
  } ctrl_t;
endpackage

// File: rtl/tcpu_ctrl.sv
module tcpu_ctrl
  import tcpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic [3:0] opcode,
  output phase_t     phase,
  output ctrl_t      ctl
);
  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    if (step) begin
      unique case (phase)
        PH_FETCH:  phaseNext = PH_DECODE;
        PH_DECODE: phaseNext = PH_EXEC;
        PH_EXEC:   phaseNext = (opcode == OP_HALT) ? PH_HALT : PH_FETCH;
        default:   phaseNext = PH_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phaseNext;
  end

  always_comb begin
    ctl = '0;
    ctl.aluOp = ALU_ADD;
    if (step) begin
      case (phase)
        PH_FETCH:  ctl.irLoad = 1'b1;
        PH_DECODE: ctl.opLoad = 1'b1;
        PH_EXEC: begin
          case (opcode)
            OP_ADD: begin ctl.rfWrite = 1'b1; ctl.flagWrite = 1'b1; ctl.aluOp = ALU_ADD; end
            OP_SUB: begin ctl.rfWrite = 1'b1; ctl.flagWrite = 1'b1; ctl.aluOp = ALU_SUB; end
            OP_AND: begin ctl.rfWrite = 1'b1; ctl.flagWrite = 1'b1; ctl.aluOp = ALU_AND; end
            OP_LDI: begin ctl.rfWrite = 1'b1; ctl.immSel = 1'b1; end
            OP_STORE: ctl.storeEn = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcpu_datapath.sv
module tcpu_datapath
  import tcpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [WORD_W-1:0] progData,
  output logic [3:0]        opcode,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] ir,
  output logic [2:0]        flags,
  output logic              dmemWe,
  output logic [7:0]        dmemAddr,
  output logic [WORD_W-1:0] dmemData
);
  localparam int IMEM_DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] imem [IMEM_DEPTH];
  logic [WORD_W-1:0] regs [REG_N];
  logic [WORD_W-1:0] opA, opB;
  logic [WORD_W-1:0] aluRes, wrData;
  logic              aluCarry;
  logic [WORD_W:0]   sumWide, diffWide;

  always_ff @(posedge clk) begin
    if (progWe) imem[progAddr] <= progData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else if (ctl.irLoad) begin
      ir <= imem[pc];
      pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opA <= '0;
      opB <= '0;
    end else if (ctl.opLoad) begin
      opA <= regs[ir[11:8]];
      opB <= regs[ir[7:4]];
    end
  end

  always_comb begin
    sumWide  = {1'b0, opA} + {1'b0, opB};
    diffWide = {1'b0, opA} - {1'b0, opB};
    case (ctl.aluOp)
      ALU_SUB: begin aluRes = diffWide[WORD_W-1:0]; aluCarry = ~diffWide[WORD_W]; end
      ALU_AND: begin aluRes = opA & opB;            aluCarry = 1'b0; end
      default: begin aluRes = sumWide[WORD_W-1:0];  aluCarry = sumWide[WORD_W]; end
    endcase
    wrData = ctl.immSel ? {{(WORD_W-8){1'b0}}, ir[11:4]} : aluRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
    end else if (ctl.rfWrite) begin
      regs[ir[3:0]] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                flags <= '0;
    else if (ctl.flagWrite) flags <= {aluRes[WORD_W-1], (aluRes == '0), aluCarry};
  end

  assign opcode   = ir[15:12];
  assign dmemWe   = ctl.storeEn;
  assign dmemAddr = ir[7:0];
  assign dmemData = opA;
endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [15:0]       progData,
  output logic [ADDR_W-1:0] pc,
  output logic [15:0]       ir,
  output logic [1:0]        phase,
  output logic [2:0]        flags,
  output logic              dmemWe,
  output logic [7:0]        dmemAddr,
  output logic [15:0]       dmemData
);
  ctrl_t      ctl;
  phase_t     phaseQ;
  logic [3:0] opcode;

  tcpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .step(step), .opcode(opcode),
    .phase(phaseQ), .ctl(ctl)
  );

  tcpu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .opcode(opcode), .pc(pc), .ir(ir), .flags(flags),
    .dmemWe(dmemWe), .dmemAddr(dmemAddr), .dmemData(dmemData)
  );

  assign phase = phaseQ;
endmodule

// File: rtl/tcpu_core_checker.sv
module tcpu_core_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic [ADDR_W-1:0] pc,
  input logic [15:0]       ir,
  input logic [1:0]        phase,
  input logic [2:0]        flags,
  input logic              dmemWe
);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pc) && $stable(ir) && $stable(phase) && $stable(flags)));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (step && phase == 2'd0) |=> phase == 2'd1);

  p_decode_to_exec_r2: assert property (@(posedge clk) disable iff (rst)
    (step && phase == 2'd1) |=> phase == 2'd2);

  p_exec_leaves_r2: assert property (@(posedge clk) disable iff (rst)
    (step && phase == 2'd2) |=> (phase == 2'd0 || phase == 2'd3));

  p_pc_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (step && phase == 2'd0) |=> pc == $past(pc) + 1'b1);

  p_ir_only_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd0) |=> $stable(ir));

  p_flags_only_exec_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd2) |=> $stable(flags));

  p_store_in_exec_r10: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> (phase == 2'd2 && step));

  p_halt_sticks_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd3) |=> (phase == 2'd3 && $stable(pc) && $stable(flags)));
endmodule

bind tcpu_core tcpu_core_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .step(step), .pc(pc), .ir(ir),
  .phase(phase), .flags(flags), .dmemWe(dmemWe)
);

// File: tb/tcpu_core_test.sv
`timescale 1ns/1ps
module tcpu_core_test;
  localparam int AW = 8;

  logic          clk = 0;
  logic          rst = 1;
  logic          step = 0;
  logic          progWe = 0;
  logic [AW-1:0] progAddr = '0;
  logic [15:0]   progData = '0;
  logic [AW-1:0] pc;
  logic [15:0]   ir;
  logic [1:0]    phase;
  logic [2:0]    flags;
  logic          dmemWe;
  logic [7:0]    dmemAddr;
  logic [15:0]   dmemData;

  always #2.5 clk = ~clk;

  tcpu_core #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .step(step), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .pc(pc), .ir(ir), .phase(phase), .flags(flags),
    .dmemWe(dmemWe), .dmemAddr(dmemAddr), .dmemData(dmemData)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0]   prog [256];
  int            progLen;
  logic [15:0]   mReg [16];
  logic [2:0]    mFlags;
  logic [AW-1:0] mPc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [18:0] aluModel(input logic [3:0] op, input logic [15:0] a,
                                           input logic [15:0] b);
    logic [16:0] w;
    logic [15:0] r;
    logic c;
    case (op)
      4'b0010: begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; c = w[16]; end
      4'b0011: begin r = a - b; c = (a >= b); end
      default: begin r = a & b; c = 1'b0; end
    endcase
    return {r[15], (r == 16'h0), c, r};
  endfunction

  task automatic loadProgram();
    for (int i = 0; i < progLen; i++) begin
      @(negedge clk);
      progWe = 1; progAddr = AW'(i); progData = prog[i];
    end
    @(negedge clk);
    progWe = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; step = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 16; i++) mReg[i] = 16'h0;
    mFlags = 3'b000; mPc = '0;
    chk(pc == 0, "R1", "pc after reset", 32'(pc), 0);
    chk(ir == 0, "R1", "ir after reset", 32'(ir), 0);
    chk(phase == 0, "R1", "phase after reset", 32'(phase), 0);
    chk(flags == 0, "R1", "flags after reset", 32'(flags), 0);
  endtask

  task automatic maybeIdle();
    if ($urandom % 4 == 0) begin
      logic [AW-1:0] p0; logic [1:0] ph0; logic [15:0] i0; logic [2:0] f0;
      p0 = pc; ph0 = phase; i0 = ir; f0 = flags;
      repeat (1 + $urandom % 3) @(negedge clk);
      chk(pc == p0 && phase == ph0 && ir == i0 && flags == f0, "R3", "hold with step low",
          {pc, phase, flags}, {p0, ph0, f0});
    end
  endtask

  task automatic pulse();
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
  endtask

  task automatic runInstr(output bit halted);
    logic [15:0] w;
    logic [3:0]  op;
    logic [18:0] a;
    w = prog[mPc];
    op = w[15:12];
    pulse();
    chk(ir == w, "R4", "ir after fetch (R13 program load)", 32'(ir), 32'(w));
    chk(pc == AW'(mPc + 1), "R4", "pc after fetch", 32'(pc), 32'(AW'(mPc + 1)));
    chk(phase == 1, "R2", "phase after fetch", 32'(phase), 1);
    mPc = AW'(mPc + 1);
    maybeIdle();
    pulse();
    chk(phase == 2, "R2", "phase after decode", 32'(phase), 2);
    maybeIdle();
    @(negedge clk); step = 1;
    #1;
    if (op == 4'b0101) begin
      chk(dmemWe == 1, "R10", "store strobe", 32'(dmemWe), 1);
      chk(dmemAddr == w[7:0], "R10", "store address", 32'(dmemAddr), 32'(w[7:0]));
      chk(dmemData == mReg[w[11:8]], "R10", "store data", 32'(dmemData), 32'(mReg[w[11:8]]));
    end else begin
      chk(dmemWe == 0, (op == 4'b0101 || op == 4'b0001 || op[3:1] == 3'b001 ||
          op == 4'b0100 || op == 4'b1111) ? "R10" : "R12", "no store strobe", 32'(dmemWe), 0);
    end
    @(negedge clk); step = 0;
    case (op)
      4'b0010, 4'b0011, 4'b0100: begin
        a = aluModel(op, mReg[w[11:8]], mReg[w[7:4]]);
        mReg[w[3:0]] = a[15:0];
        mFlags = a[18:16];
      end
      4'b0001: mReg[w[3:0]] = {8'h00, w[11:4]};
      default: ;
    endcase
    halted = (op == 4'b1111);
    chk(flags == mFlags, op == 4'b0010 ? "R5" : op == 4'b0011 ? "R6" :
        op == 4'b0100 ? "R7" : "R8", "flags after execute", 32'(flags), 32'(mFlags));
    chk(phase == (halted ? 2'd3 : 2'd0), halted ? "R11" : "R2", "phase after execute",
        32'(phase), halted ? 3 : 0);
  endtask

  task automatic runProgram();
    bit h;
    int n;
    h = 0; n = 0;
    while (!h && n < 250) begin
      runInstr(h);
      n++;
    end
    chk(h, "R11", "program reached halt", 32'(h), 1);
    begin
      logic [AW-1:0] p0;
      p0 = pc;
      repeat (5) begin
        @(negedge clk); step = 1; #1;
        chk(dmemWe == 0, "R11", "no store after halt", 32'(dmemWe), 0);
      end
      @(negedge clk); step = 0;
      chk(pc == p0 && phase == 3, "R11", "frozen after halt", {pc, phase}, {p0, 2'd3});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    // directed program
    prog[0]  = 16'h1051; // R1 = 5
    prog[1]  = 16'h1032; // R2 = 3
    prog[2]  = 16'h2123; // R3 = R1+R2 = 8, flags 000
    prog[3]  = 16'h5310; // store R3
    prog[4]  = 16'h3214; // R4 = 3-5 = FFFE, N, borrow
    prog[5]  = 16'h3115; // R5 = 0, Z C
    prog[6]  = 16'h1006; // R6 = 0, flags kept
    prog[7]  = 16'h1018; // R8 = 1
    prog[8]  = 16'h3689; // R9 = FFFF
    prog[9]  = 16'h298A; // R10 = 0 with carry out
    prog[10] = 16'h449B; // R11 = FFFE, C cleared
    prog[11] = 16'h7123; // undefined: no effect
    prog[12] = 16'h5311; // store R3 still 8 (R12)
    prog[13] = 16'h5712; // store R7 = 0 after reset (R1)
    prog[14] = 16'h5B13; // store R11
    prog[15] = 16'h5A14; // store R10
    prog[16] = 16'hF000; // halt
    progLen = 17;
    loadProgram();
    doReset();
    runProgram();

    // random programs
    for (int t = 0; t < 6; t++) begin
      int k;
      k = 0;
      for (int i = 0; i < 8; i++) begin
        prog[k] = {4'b0001, 8'($urandom), 4'($urandom)}; k++;
      end
      for (int i = 0; i < 60; i++) begin
        int sel;
        logic [3:0] op;
        sel = $urandom % 8;
        case (sel)
          0, 1: op = 4'b0010;
          2, 3: op = 4'b0011;
          4:    op = 4'b0100;
          5:    op = 4'b0001;
          6:    op = 4'b0101;
          default: op = ($urandom % 2) ? 4'b0110 : 4'b1010;
        endcase
        prog[k] = {op, 12'($urandom)}; k++;
      end
      for (int r = 0; r < 16; r++) begin
        prog[k] = {4'b0101, 4'(r), 8'(8'h80 + r)}; k++;
      end
      prog[k] = 16'hF000; k++;
      progLen = k;
      loadProgram();
      doReset();
      runProgram();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule